// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block carries out the internal self-test path of a UART. A loopback-enable field in the control register selects the path. While it is set, the block drives the four modem status flags from the modem control outputs. After every control-register update it rebuilds the four modem-status interrupt bits from those flags. It also turns transmit writes and send-break requests into pushes on the receive-buffer port, and it drops characters that arrive from the external receiver. While loopback is clear, external receive characters pass straight to the push port, and the flags and interrupt bits keep their values.

Loopback works on whole words, not on serial bits. A transmit write produces a push in the same cycle. A rising edge of the send-break bit produces a push of a break word, which has only bit `BRK_POS` set. When a transmit write and a break edge arrive in the same cycle, the transmit word goes first and the break word goes out in the next free cycle. Flag and interrupt updates appear one clock after the control-register write strobe.

Top module: `uart_lpbk_ctrl`

## Requirements
- R1: After reset, `mdm_flags`, `ms_irq` and `ms_irq_upd` are 0, and `rx_push` is 0 while no transmit or receive input is active.
- R2: When `ctl_wr` is high with `ctl_lpbk` high, `mdm_flags` shows the mapping from the next cycle on. The mapping is bit 0 (ring) = `ctl_out2`, bit 1 (clear-to-send) = `ctl_rts`, bit 2 (carrier) = `ctl_out1` and bit 3 (data-set-ready) = `ctl_dtr`.
- R3: A control write whose only change is setting `ctl_lpbk` still applies the R2 mapping.
- R4: One cycle after each R2 update, `ms_irq_upd` pulses for one cycle and `ms_irq` equals the new flags. Bits whose flag is now 0 are cleared; the bit order is the same as in R2.
- R5: A control write with `ctl_lpbk` low, and any cycle without a control write, leaves `mdm_flags` and `ms_irq` unchanged and keeps `ms_irq_upd` low.
- R6: While `ctl_lpbk` is high, `tx_wr` raises `rx_push` in the same cycle, and `rx_word` is `tx_data` zero-extended.
- R7: While `ctl_lpbk` is high, a 0-to-1 change of `brk_req` pushes a word with only bit `BRK_POS` (default 10) set, in that cycle if `tx_wr` is low. Holding `brk_req` high pushes nothing more.
- R8: When a break edge meets `tx_wr` in the same cycle, the transmit word is pushed first. The break word follows in the first later cycle without `tx_wr`.
- R9: While `ctl_lpbk` is high, `ext_rx_vld` causes no push.
- R10: While `ctl_lpbk` is low, `rx_push` equals `ext_rx_vld` and `rx_word` equals `ext_rx_word`. `tx_wr` and break edges push nothing.
- R11: A break that is still waiting behind a transmit write is dropped if `ctl_lpbk` goes low before the break word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register written this cycle; the fields below already hold the new value |
| ctl_lpbk | input | 1 | Loopback enable field |
| ctl_out2 | input | 1 | User output 2 field |
| ctl_out1 | input | 1 | User output 1 field |
| ctl_rts | input | 1 | Request-to-send field |
| ctl_dtr | input | 1 | Data-terminal-ready field |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Transmit data word |
| brk_req | input | 1 | Send-break control bit |
| ext_rx_vld | input | 1 | External receiver has a word |
| ext_rx_word | input | WORD_W | External receiver word |
| mdm_flags | output | 4 | Modem status flags {dsr, dcd, cts, ri} |
| ms_irq | output | 4 | Modem interrupt set values, same order |
| ms_irq_upd | output | 1 | ms_irq has just been rebuilt |
| rx_push | output | 1 | Receive buffer push request |
| rx_word | output | WORD_W | Word to push |

## Verification
The assertions check on every cycle that the flags follow the control mapping after a loopback write and stay unchanged otherwise. They also check that the interrupt bits match the flags on each rebuild, that transmit writes are mirrored in the same cycle, and that the push path while loopback is clear is exactly the external receiver. Other behaviours need a sequence of inputs and only the bench's scenarios can show them: a write that only sets the enable bit, a break edge versus a held break, a break colliding with a transmit write, and a pending break that is dropped when loopback turns off.

// File: rtl/ulb_pkg.sv
package ulb_pkg;
   localparam int MDM_N   = 4;
   localparam int MDM_RI  = 0;
   localparam int MDM_CTS = 1;
   localparam int MDM_DCD = 2;
   localparam int MDM_DSR = 3;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_TX   = 2'd1,
      SRC_BRK  = 2'd2,
      SRC_EXT  = 2'd3
   } push_src_e;
endpackage

// File: rtl/ulb_modem_map.sv
module ulb_modem_map #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_en,
   input  logic [N-1:0] ctl_outs,
   output logic [N-1:0] flags,
   output logic [N-1:0] irq,
   output logic         irq_upd
);
   generate
      if (N < 1) begin : g_bad_n
         $error("ulb_modem_map: N must be at least 1");
      end
   endgenerate

   // One flag/interrupt pair per modem line; both rebuilt wholesale on update.
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_line
         logic flag_q;
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
               irq_q  <= 1'b0;
            end else if (upd_en) begin
               flag_q <= ctl_outs[gi];
               irq_q  <= ctl_outs[gi];
            end
         end
         assign flags[gi] = flag_q;
         assign irq[gi]   = irq_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_upd <= 1'b0;
      else        irq_upd <= upd_en;
   end
endmodule

// File: rtl/ulb_brk_edge.sv
module ulb_brk_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lpbk,
   input  logic brk,
   input  logic tx_busy,
   output logic fire
);
   logic brk_q;
   logic pend_q;
   logic pend_n;
   logic rise;

   assign rise = lpbk & brk & ~brk_q;
   assign fire = lpbk & ~tx_busy & (rise | pend_q);

   always_comb begin
      pend_n = pend_q;
      if (!lpbk)                pend_n = 1'b0;
      else if (rise && tx_busy) pend_n = 1'b1;
      else if (fire)            pend_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         brk_q  <= brk;
         pend_q <= pend_n;
      end
   end
endmodule

// File: rtl/ulb_push_sel.sv
module ulb_push_sel
   import ulb_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int WORD_W  = 12,
   parameter int BRK_POS = 10
) (
   input  logic              lpbk,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              brk_fire,
   input  logic              ext_vld,
   input  logic [WORD_W-1:0] ext_word,
   output logic              push,
   output logic [WORD_W-1:0] word
);
   localparam int PAD_W = WORD_W - DATA_W;
   localparam logic [WORD_W-1:0] BRK_WORD = {{(WORD_W-1){1'b0}}, 1'b1} << BRK_POS;

   generate
      if (PAD_W < 1) begin : g_bad_w
         $error("ulb_push_sel: WORD_W must exceed DATA_W");
      end
   endgenerate

   push_src_e src;

   always_comb begin
      if (lpbk) begin
         if (tx_wr)         src = SRC_TX;
         else if (brk_fire) src = SRC_BRK;
         else               src = SRC_NONE;
      end else begin
         src = ext_vld ? SRC_EXT : SRC_NONE;
      end
   end

   always_comb begin
      push = (src != SRC_NONE);
      unique case (src)
         SRC_TX:  word = {{PAD_W{1'b0}}, tx_data};
         SRC_BRK: word = BRK_WORD;
         SRC_EXT: word = ext_word;
         default: word = '0;
      endcase
   end
endmodule

// File: rtl/uart_lpbk_ctrl.sv
module uart_lpbk_ctrl
   import ulb_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int WORD_W  = 12,
   parameter int BRK_POS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_lpbk,
   input  logic              ctl_out2,
   input  logic              ctl_out1,
   input  logic              ctl_rts,
   input  logic              ctl_dtr,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              brk_req,
   input  logic              ext_rx_vld,
   input  logic [WORD_W-1:0] ext_rx_word,
   output logic [3:0]        mdm_flags,
   output logic [3:0]        ms_irq,
   output logic              ms_irq_upd,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word
);
   generate
      if (BRK_POS >= WORD_W) begin : g_bad_brk
         $error("uart_lpbk_ctrl: BRK_POS must lie inside WORD_W");
      end
      if (DATA_W > BRK_POS) begin : g_bad_data
         $error("uart_lpbk_ctrl: data bits must sit below BRK_POS");
      end
   endgenerate

   logic [MDM_N-1:0] outs_map;
   logic             map_upd;
   logic             brk_fire;

   always_comb begin
      outs_map          = '0;
      outs_map[MDM_RI]  = ctl_out2;
      outs_map[MDM_CTS] = ctl_rts;
      outs_map[MDM_DCD] = ctl_out1;
      outs_map[MDM_DSR] = ctl_dtr;
   end

   assign map_upd = ctl_wr & ctl_lpbk;

   ulb_modem_map #(.N(MDM_N)) map_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (map_upd),
      .ctl_outs (outs_map),
      .flags    (mdm_flags),
      .irq      (ms_irq),
      .irq_upd  (ms_irq_upd)
   );

   ulb_brk_edge brk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lpbk    (ctl_lpbk),
      .brk     (brk_req),
      .tx_busy (tx_wr),
      .fire    (brk_fire)
   );

   ulb_push_sel #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BRK_POS(BRK_POS)) sel_i (
      .lpbk     (ctl_lpbk),
      .tx_wr    (tx_wr),
      .tx_data  (tx_data),
      .brk_fire (brk_fire),
      .ext_vld  (ext_rx_vld),
      .ext_word (ext_rx_word),
      .push     (rx_push),
      .word     (rx_word)
   );
endmodule

// File: rtl/ulb_chk.sv
module ulb_chk #(
   parameter int DATA_W  = 8,
   parameter int WORD_W  = 12,
   parameter int BRK_POS = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr,
   input logic              ctl_lpbk,
   input logic              ctl_out2,
   input logic              ctl_out1,
   input logic              ctl_rts,
   input logic              ctl_dtr,
   input logic              tx_wr,
   input logic [DATA_W-1:0] tx_data,
   input logic              ext_rx_vld,
   input logic [WORD_W-1:0] ext_rx_word,
   input logic [3:0]        mdm_flags,
   input logic [3:0]        ms_irq,
   input logic              ms_irq_upd,
   input logic              rx_push,
   input logic [WORD_W-1:0] rx_word
);
   localparam logic [WORD_W-1:0] BRK_W = {{(WORD_W-1){1'b0}}, 1'b1} << BRK_POS;

   AST_FLAG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_lpbk) |=> (mdm_flags == $past({ctl_dtr, ctl_out1, ctl_rts, ctl_out2}))); // R2
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr && ctl_lpbk) |=> ($stable(mdm_flags) && $stable(ms_irq) && !ms_irq_upd)); // R5
   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ms_irq_upd |-> (ms_irq == mdm_flags)); // R4
   AST_TX_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && ctl_lpbk) |-> (rx_push && rx_word == WORD_W'(tx_data))); // R6
   AST_EXT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_lpbk && !tx_wr && rx_push) |-> (rx_word == BRK_W)); // R9
   AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_lpbk |-> (rx_push == ext_rx_vld && (!ext_rx_vld || rx_word == ext_rx_word))); // R10
endmodule

bind uart_lpbk_ctrl ulb_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BRK_POS(BRK_POS)) chk_i (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_lpbk(ctl_lpbk),
   .ctl_out2(ctl_out2), .ctl_out1(ctl_out1), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
   .tx_wr(tx_wr), .tx_data(tx_data), .ext_rx_vld(ext_rx_vld), .ext_rx_word(ext_rx_word),
   .mdm_flags(mdm_flags), .ms_irq(ms_irq), .ms_irq_upd(ms_irq_upd),
   .rx_push(rx_push), .rx_word(rx_word)
);

// File: tb/uart_lpbk_ctrl_tb_top.sv
module uart_lpbk_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 8;
   localparam int WORD_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 0, ctl_lpbk = 0, ctl_out2 = 0, ctl_out1 = 0, ctl_rts = 0, ctl_dtr = 0;
   logic tx_wr = 0;
   logic [DATA_W-1:0] tx_data = '0;
   logic brk_req = 0;
   logic ext_rx_vld = 0;
   logic [WORD_W-1:0] ext_rx_word = '0;
   logic [3:0] mdm_flags, ms_irq;
   logic ms_irq_upd, rx_push;
   logic [WORD_W-1:0] rx_word;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_lpbk_ctrl #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BRK_POS(10)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_lpbk(ctl_lpbk),
      .ctl_out2(ctl_out2), .ctl_out1(ctl_out1), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
      .tx_wr(tx_wr), .tx_data(tx_data), .brk_req(brk_req),
      .ext_rx_vld(ext_rx_vld), .ext_rx_word(ext_rx_word),
      .mdm_flags(mdm_flags), .ms_irq(ms_irq), .ms_irq_upd(ms_irq_upd),
      .rx_push(rx_push), .rx_word(rx_word)
   );

   // {lpbk, out2, out1, rts, dtr, expected flags {dsr,dcd,cts,ri}, expected update pulse}
   localparam logic [9:0] VEC [9] = '{
      10'b1_1000_0001_1,   // R2 ring from out2
      10'b1_0010_0010_1,   // R2 cts from rts, R4 ring bit cleared
      10'b1_0100_0100_1,   // R2 dcd from out1
      10'b1_0001_1000_1,   // R2 dsr from dtr
      10'b0_1111_1000_0,   // R5 loopback off: hold
      10'b1_1111_1111_1,   // R2 all set
      10'b0_0010_1111_0,   // R5 hold while only rts set
      10'b1_0010_0010_1,   // R3 only the enable bit changes
      10'b1_0000_0000_1    // R4 all interrupt bits cleared
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 flags", 32'(mdm_flags), 0);
      chk("R1 irq", 32'(ms_irq), 0);
      chk("R1 upd", 32'(ms_irq_upd), 0);
      chk("R1 push", 32'(rx_push), 0);

      for (int i = 0; i < 9; i++) begin
         {ctl_lpbk, ctl_out2, ctl_out1, ctl_rts, ctl_dtr} = VEC[i][9:5];
         ctl_wr = 1'b1;
         tick();
         ctl_wr = 1'b0;
         chk("R2/R3/R5 flags", 32'(mdm_flags), 32'(VEC[i][4:1]));
         chk("R4 irq bits", 32'(ms_irq), 32'(VEC[i][4:1]));
         chk("R4/R5 upd pulse", 32'(ms_irq_upd), 32'(VEC[i][0]));
         tick();
         chk("R4 upd one cycle", 32'(ms_irq_upd), 0);
      end

      // loopback is on from the last vector
      tx_wr = 1; tx_data = 8'hA5; #1;
      chk("R6 push", 32'(rx_push), 1);
      chk("R6 word", 32'(rx_word), 32'h0A5);
      tick(); tx_wr = 0;

      ext_rx_vld = 1; ext_rx_word = 12'h055; #1;
      chk("R9 ext blocked", 32'(rx_push), 0);
      tick(); ext_rx_vld = 0;

      brk_req = 1; #1;
      chk("R7 break push", 32'(rx_push), 1);
      chk("R7 break word", 32'(rx_word), 32'h400);
      tick(); #1;
      chk("R7 held no repeat", 32'(rx_push), 0);
      brk_req = 0; tick();

      brk_req = 1; tx_wr = 1; tx_data = 8'h3C; #1;
      chk("R8 tx first", 32'(rx_word), 32'h03C);
      tick(); tx_wr = 0; #1;
      chk("R8 break next push", 32'(rx_push), 1);
      chk("R8 break next word", 32'(rx_word), 32'h400);
      tick(); #1;
      chk("R8 single break", 32'(rx_push), 0);
      brk_req = 0; tick();

      brk_req = 1; tx_wr = 1; tx_data = 8'h11;
      tick(); tx_wr = 0; ctl_lpbk = 0; #1;
      chk("R11 no push while off", 32'(rx_push), 0);
      tick(); ctl_lpbk = 1; #1;
      chk("R11 pending dropped", 32'(rx_push), 0);
      tick(); brk_req = 0; ctl_lpbk = 0; tick();

      ext_rx_vld = 1; ext_rx_word = 12'h2C3; #1;
      chk("R10 ext push", 32'(rx_push), 1);
      chk("R10 ext word", 32'(rx_word), 32'h2C3);
      tick(); ext_rx_vld = 0;
      tx_wr = 1; tx_data = 8'h77; #1;
      chk("R10 tx ignored", 32'(rx_push), 0);
      tick(); tx_wr = 0;
      brk_req = 1; #1;
      chk("R10 break ignored", 32'(rx_push), 0);
      tick(); brk_req = 0; tick();
      chk("R5 flags untouched", 32'(mdm_flags), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule